// File: doc/BRIEF.md
# Near-Far Write Slot Allocator

This block decides which line of a small shared store receives each incoming write. It keeps a circular pointer over the lines. The pointer marks the oldest line. The block also reads one occupancy flag per line, driven from outside. For every accepted write request it returns a target line index and an overwrite indicator, with a one-cycle grant pulse.

Placement follows three rules:
- If the line under the pointer is free, the write goes there and the pointer steps forward.
- If that line is taken but some other line is free, the write goes to the nearest free line after the pointer. The pointer does not move.
- If no line is free, the line under the pointer is overwritten in FIFO order and the pointer steps forward.

A line that has just been granted counts as occupied until its external flag is seen set. This means back-to-back requests never land on the same free line. The number of lines is always a power of two, set through the index width parameter.

Top module: `nfa_slot_alloc`

## Requirements
- R1: While `rst` is high, `req_ready_o`, `grant_o` and `grant_ovw_o` are 0, the pointer is at line 0, and all claims are dropped. The first request on an empty store is placed at line 0.
- R2: A request is accepted on a rising edge where `req_valid_i` and `req_ready_o` are both 1.
  - `req_ready_o` rises on the first edge after reset is released and stays high, so one request can be accepted every cycle.
  - `grant_o` is 1 for exactly the cycle after each acceptance. In that cycle `grant_idx_o` and `grant_ovw_o` are valid. Otherwise `grant_o` is 0.
- R3: A line is effectively occupied when its flag in `occ_i` is 1 (1 = occupied, bit i = line i) or when it is claimed (R8). If the line under the pointer is effectively free, the grant targets the pointer, `grant_ovw_o` is 0, and the pointer advances by one.
- R4: If the pointer line is effectively occupied and another line is free, the grant targets the first free line in the order pointer+1, pointer+2, … (modulo the line count). `grant_ovw_o` is 0 and the pointer keeps its value.
- R5: If every line is effectively occupied, the grant targets the pointer line, `grant_ovw_o` is 1, and the pointer advances by one.
- R6: The pointer advances from line N-1 to line 0.
- R7: Starting empty with all flags 0, N back-to-back requests are granted lines 0, 1, …, N-1 in order, none of them an overwrite.
- R8: A granted line is claimed from the grant cycle onward. It counts as occupied until a rising edge at which its `occ_i` bit is 1; from then on only `occ_i` decides its state.
- R9: A line whose claim has been released and whose `occ_i` bit is cleared is free again and can be granted without overwrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| occ_i | input | 2**LINE_BITS | Per-line occupancy flags, 1 = occupied |
| req_valid_i | input | 1 | Write placement request |
| req_ready_o | output | 1 | Allocator can accept a request |
| grant_o | output | 1 | One-cycle pulse: a placement result is valid |
| grant_idx_o | output | LINE_BITS | Target line of the granted write |
| grant_ovw_o | output | 1 | Granted write overwrites an occupied line |

## Verification
The bench goes after these corner cases:
- **Pointer hold after a remote placement.** A design that advanced the pointer anyway would send the following request one line too far.
- **Free line just behind the pointer.** This forces the circular search to wrap through the top of the index range. A linear search from line 0 would pick the wrong line.
- **Bursts of requests with the flags held at zero.** A missing claim mask would hand out the same line twice.
- **Full store.** A design without the overwrite fallback would report no overwrite or target a remote line.

Random occupancy patterns are compared against an independent model of the pointer and the claims, including the point where the pointer crosses from the last line to line 0.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  // How the target line of one request was chosen.
  typedef enum logic [1:0] {
    PICK_PTR    = 2'd0,
    PICK_REMOTE = 2'd1,
    PICK_OVW    = 2'd2
  } pick_e;
endpackage

// File: rtl/nfa_free_scan.sv
// Circular first-free search starting one past the base index.
module nfa_free_scan #(
  parameter int LINE_BITS = 3,
  localparam int LINES = 1 << LINE_BITS
) (
  input  logic [LINES-1:0]     busy_i,
  input  logic [LINE_BITS-1:0] base_i,
  output logic                 found_o,
  output logic [LINE_BITS-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = base_i;
    // Walk from the far end back so the nearest offset wins.
    for (int i = LINES - 1; i >= 1; i--) begin
      logic [LINE_BITS-1:0] cand;
      cand = base_i + LINE_BITS'(i);
      if (!busy_i[cand]) begin
        found_o = 1'b1;
        idx_o   = cand;
      end
    end
  end
endmodule

// File: rtl/nfa_claim_mask.sv
// Holds lines granted but not yet reported occupied by the store.
module nfa_claim_mask #(
  parameter int LINE_BITS = 3,
  localparam int LINES = 1 << LINE_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LINES-1:0]     occ_i,
  input  logic                 set_en_i,
  input  logic [LINE_BITS-1:0] set_idx_i,
  output logic [LINES-1:0]     claimed_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit;
    assign hit = set_en_i && (set_idx_i == LINE_BITS'(g));
    always_ff @(posedge clk) begin
      if (rst)
        claimed_o[g] <= 1'b0;
      else
        claimed_o[g] <= (claimed_o[g] & ~occ_i[g]) | hit;
    end
  end
endmodule

// File: rtl/nfa_slot_alloc.sv
module nfa_slot_alloc
  import nfa_pkg::*;
#(
  parameter int LINE_BITS = 3,
  localparam int LINES = 1 << LINE_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LINES-1:0]     occ_i,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  output logic                 grant_o,
  output logic [LINE_BITS-1:0] grant_idx_o,
  output logic                 grant_ovw_o
);
  localparam logic [LINE_BITS-1:0] STEP = 1;

  logic [LINE_BITS-1:0] ptr_q;
  logic [LINES-1:0]     claimed;
  logic [LINES-1:0]     eff_occ;
  logic                 rem_found;
  logic [LINE_BITS-1:0] rem_idx;
  logic [LINE_BITS-1:0] tgt;
  pick_e                pick;
  logic                 accept;

  assign eff_occ = occ_i | claimed;
  assign accept  = req_valid_i && req_ready_o;

  nfa_free_scan #(.LINE_BITS(LINE_BITS)) u_scan (
    .busy_i (eff_occ),
    .base_i (ptr_q),
    .found_o(rem_found),
    .idx_o  (rem_idx)
  );

  always_comb begin
    if (!eff_occ[ptr_q]) begin
      pick = PICK_PTR;
      tgt  = ptr_q;
    end else if (rem_found) begin
      pick = PICK_REMOTE;
      tgt  = rem_idx;
    end else begin
      pick = PICK_OVW;
      tgt  = ptr_q;
    end
  end

  nfa_claim_mask #(.LINE_BITS(LINE_BITS)) u_claim (
    .clk      (clk),
    .rst      (rst),
    .occ_i    (occ_i),
    .set_en_i (accept),
    .set_idx_i(tgt),
    .claimed_o(claimed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q       <= '0;
      req_ready_o <= 1'b0;
      grant_o     <= 1'b0;
      grant_idx_o <= '0;
      grant_ovw_o <= 1'b0;
    end else begin
      req_ready_o <= 1'b1;
      grant_o     <= accept;
      if (accept) begin
        grant_idx_o <= tgt;
        grant_ovw_o <= (pick == PICK_OVW);
        if (pick != PICK_REMOTE)
          ptr_q <= ptr_q + STEP;
      end
    end
  end

  // Checker state: previous-cycle view of pointer and occupancy.
  logic [LINE_BITS-1:0] ptr_d;
  logic [LINES-1:0]     eff_d;
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_d <= '0;
      eff_d <= '0;
    end else begin
      ptr_d <= ptr_q;
      eff_d <= eff_occ;
    end
  end

  a_r2_grant_follows_accept: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> $past(req_valid_i && req_ready_o));
  a_r3_free_target: assert property (@(posedge clk) disable iff (rst)
    (grant_o && !grant_ovw_o) |-> !eff_d[grant_idx_o]);
  a_r4_ptr_hold_remote: assert property (@(posedge clk) disable iff (rst)
    (grant_o && grant_idx_o != ptr_d) |-> (ptr_q == ptr_d));
  a_r5_ovw_only_full: assert property (@(posedge clk) disable iff (rst)
    (grant_o && grant_ovw_o) |-> ((&eff_d) && grant_idx_o == ptr_d));
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (grant_o && grant_idx_o == ptr_d) |-> (ptr_q == ptr_d + STEP));
  a_r8_claim_set: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> claimed[grant_idx_o]);
  a_r2_idle_ptr: assert property (@(posedge clk) disable iff (rst)
    !grant_o |-> $stable(ptr_q));
endmodule

// File: tb/sim_nfa_slot_alloc.sv
`timescale 1ns/1ps
module sim_nfa_slot_alloc;
  localparam int LB = 3;
  localparam int N  = 1 << LB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  occ = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          grant;
  logic [LB-1:0] grant_idx;
  logic          grant_ovw;

  int n_chk  = 0;
  int n_fail = 0;

  // Reference model state.
  int           m_ptr = 0;
  logic [N-1:0] m_claim = '0;

  always #2 clk = ~clk;

  nfa_slot_alloc #(.LINE_BITS(LB)) u0 (
    .clk(clk), .rst(rst), .occ_i(occ), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .grant_o(grant), .grant_idx_o(grant_idx),
    .grant_ovw_o(grant_ovw)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One clock: drive at negedge, check at the next negedge.
  task automatic step(input bit v, input string tag);
    logic [N-1:0] eff;
    int  e_idx;
    bit  e_ovw;
    bit  remote;
    string t;
    eff    = occ | m_claim;
    e_idx  = m_ptr;
    e_ovw  = 1'b0;
    remote = 1'b0;
    if (eff[m_ptr]) begin
      e_ovw = 1'b1;
      for (int i = N - 1; i >= 1; i--)
        if (!eff[(m_ptr + i) % N]) begin
          e_idx  = (m_ptr + i) % N;
          e_ovw  = 1'b0;
          remote = 1'b1;
        end
    end
    t = remote ? "R4" : (e_ovw ? "R5" : "R3");
    req_valid = v;
    @(posedge clk);
    m_claim = m_claim & ~occ;
    if (v) begin
      m_claim[e_idx] = 1'b1;
      if (!remote) m_ptr = (m_ptr + 1) % N;
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (v) begin
      chk(grant == 1'b1, {tag, "/R2"}, "grant", grant, 1);
      chk(int'(grant_idx) == e_idx, {tag, "/", t}, "index", grant_idx, e_idx);
      chk(grant_ovw == e_ovw, {tag, "/", t}, "overwrite", grant_ovw, e_ovw);
    end else begin
      chk(grant == 1'b0, {tag, "/R2"}, "idle grant", grant, 0);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; req_valid = 1'b1; occ = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b0, "R1", "ready in reset", req_ready, 0);
    chk(grant == 1'b0, "R1", "grant in reset", grant, 0);
    chk(grant_ovw == 1'b0, "R1", "ovw in reset", grant_ovw, 0);
    rst = 1'b0; req_valid = 1'b0;
    m_ptr = 0; m_claim = '0;
    @(posedge clk);
    m_claim = m_claim & ~occ;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready after reset", req_ready, 1);
    chk(grant == 1'b0, "R2", "no grant without valid", grant, 0);
  endtask

  // Empty store, flags held at 0: claims alone keep lines distinct.
  task automatic t_fill();
    for (int k = 0; k < N; k++) begin
      step(1'b1, "R7");
      chk(int'(grant_idx) == k, "R7/R8", "fill order", grant_idx, k);
    end
    step(1'b1, "R5");
    chk(int'(grant_idx) == 0 && grant_ovw, "R6", "wrap overwrite at 0", grant_idx, 0);
    step(1'b0, "R2");
  endtask

  // Release all claims via flags, then clear flags: lines free again.
  task automatic t_release();
    occ = '1; step(1'b0, "R8");
    occ = '0; step(1'b1, "R9");
    chk(grant_ovw == 1'b0, "R9", "released line free", grant_ovw, 0);
  endtask

  task automatic t_remote_wrap();
    int p;
    occ = '1; step(1'b0, "R8");
    p = m_ptr;
    occ = '1; occ[(p + N - 1) % N] = 1'b0;
    step(1'b1, "R4");
    chk(int'(grant_idx) == (p + N - 1) % N, "R4", "wrapped search", grant_idx, (p + N - 1) % N);
    occ = '1; occ[p] = 1'b0;
    step(1'b1, "R4");
    chk(int'(grant_idx) == p, "R4", "pointer held", grant_idx, p);
    occ = '1;
    step(1'b1, "R5");
    chk(int'(grant_idx) == (p + 1) % N && grant_ovw, "R5", "full overwrite", grant_idx, (p + 1) % N);
  endtask

  task automatic t_first_free();
    int p;
    occ = '1; step(1'b0, "R8");
    p = m_ptr;
    occ = '1; occ[(p + 2) % N] = 1'b0; occ[(p + 5) % N] = 1'b0;
    step(1'b1, "R4");
    chk(int'(grant_idx) == (p + 2) % N, "R4", "nearest free", grant_idx, (p + 2) % N);
  endtask

  task automatic t_random();
    for (int k = 0; k < 60; k++) begin
      occ = N'($urandom);
      step(($urandom % 4) != 0, "R3");
    end
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fill();
    t_release();
    t_remote_wrap();
    t_first_free();
    t_random();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule